// File: doc/BRIEF.md
# Dual-Bank I/O Field Merge Unit

This block holds the two byte-wide latched output banks (left and right) of a small controller's I/O bus and performs the bit-field work around them. A read request pulls a field of 1 to 8 bits out of either bank and returns it right-justified. A write request takes a right-justified value and merges it into a field of one bank. All bits outside that field keep their values.

Both kinds of request name a bank, an end position and a length code. Positions are counted from the most significant bit, so position 7 is the least significant bit. The end position gives the field's least significant bit, and the field extends from there towards the MSB. A length code of zero selects the full byte.

Every bank write appears on that bank's output port with a one-cycle strobe. A transmit flavour of the write limits the written value to a 5-bit immediate.

Top module: `iofield_unit`

## Requirements
- R1: While reset is asserted and directly after it, both bank ports read 0x00, both strobes are low and `rd_data_valid` is low.
- R2: A length code of 0 selects an 8-bit field. Codes 1 to 7 select that many bits.
- R3: A read returns `rotate_right(bank, 7 - pos)` masked to the field length, with every bit above the length cleared. It appears on `rd_data` with `rd_data_valid` high in the cycle after the request.
- R4: A write with shift amount s = 7 - pos forms mask = (length ones) << s and truncates it to 8 bits. The bank becomes (bank AND NOT mask) OR ((value << s) AND mask). Bits outside the mask never change, so a field that would extend past the MSB is cut off there.
- R5: A write changes only the bank that `wr_bank` selects (0 = left, 1 = right). With no write request, neither bank changes.
- R6: The cycle after a write request, the written bank's port shows the new contents and its strobe is high for exactly that one cycle. At most one strobe is ever high.
- R7: With `wr_xmit` high, the written value is `wr_data[4:0]` zero-extended. `wr_data[7:5]` is ignored.
- R8: If a write and a read target the same bank in the same cycle, the read returns the field of the merged (post-write) contents. A read of the other bank sees its current contents.
- R9: A read request leaves both banks unchanged and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request this cycle |
| wr_bank | input | 1 | Write bank: 0 left, 1 right |
| wr_xmit | input | 1 | Transmit flavour: use 5-bit immediate |
| wr_pos | input | 3 | Write field end position (MSB-first numbering) |
| wr_len | input | 3 | Write field length code (0 = 8 bits) |
| wr_data | input | 8 | Right-justified write value |
| rd_valid | input | 1 | Read request this cycle |
| rd_bank | input | 1 | Read bank: 0 left, 1 right |
| rd_pos | input | 3 | Read field end position |
| rd_len | input | 3 | Read field length code (0 = 8 bits) |
| rd_data | output | 8 | Right-justified read field |
| rd_data_valid | output | 1 | `rd_data` holds a new result |
| left_port | output | 8 | Left bank contents |
| left_strobe | output | 1 | Left bank written last cycle |
| right_port | output | 8 | Right bank contents |
| right_strobe | output | 1 | Right bank written last cycle |

## Verification
The assertions assume that every request input is at a known level whenever its valid is high, and that reset is applied from time zero. Every position and length code is legal, so the properties place no limit on them.

The stimulus changes inputs only on the falling clock edge and holds reset low from the start. It sweeps every bank, position and length code with both plain and transmit writes, then sweeps every read field against preloaded contents. This keeps each request fully defined for the one rising edge that takes it.

// File: rtl/iofm_pkg.sv
package iofm_pkg;

    localparam int IOFM_NBANK = 2;

    typedef enum logic {
        IOFM_LEFT  = 1'b0,
        IOFM_RIGHT = 1'b1
    } iofm_bank_e;

endpackage

// File: rtl/iofm_lenmask.sv
module iofm_lenmask #(
    parameter int W  = 8,
    parameter int PW = $clog2(W)
) (
    input  logic [PW-1:0] len_code,
    output logic [W-1:0]  ones
);
    // a zero code selects the full width
    always_comb begin
        if (len_code == '0) begin
            ones = '1;
        end else begin
            ones = (W'(1) << len_code) - W'(1);
        end
    end
endmodule

// File: rtl/iofm_extract.sv
module iofm_extract #(
    parameter int W  = 8,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  bank,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] len_code,
    output logic [W-1:0]  field
);
    logic [W-1:0]   ones;
    logic [PW-1:0]  amt;
    logic [2*W-1:0] dbl;

    iofm_lenmask #(.W(W), .PW(PW)) u_mask (
        .len_code (len_code),
        .ones     (ones)
    );

    // rotate right by (W-1-pos) through a doubled copy
    always_comb begin
        amt   = PW'(W - 1) - pos;
        dbl   = {bank, bank} >> amt;
        field = dbl[W-1:0] & ones;
    end
endmodule

// File: rtl/iofm_merge.sv
module iofm_merge #(
    parameter int W  = 8,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  cur,
    input  logic [W-1:0]  val,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] len_code,
    output logic [W-1:0]  nxt,
    output logic [W-1:0]  wmask
);
    logic [W-1:0]  ones;
    logic [PW-1:0] shl;

    iofm_lenmask #(.W(W), .PW(PW)) u_mask (
        .len_code (len_code),
        .ones     (ones)
    );

    // shift (not rotate): bits pushed past the MSB are dropped
    always_comb begin
        shl   = PW'(W - 1) - pos;
        wmask = ones << shl;
        nxt   = (cur & ~wmask) | ((val << shl) & wmask);
    end
endmodule

// File: rtl/iofield_unit.sv
module iofield_unit #(
    parameter int W      = 8,
    parameter int XMIT_W = 5,
    parameter int PW     = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          wr_bank,
    input  logic          wr_xmit,
    input  logic [PW-1:0] wr_pos,
    input  logic [PW-1:0] wr_len,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_valid,
    input  logic          rd_bank,
    input  logic [PW-1:0] rd_pos,
    input  logic [PW-1:0] rd_len,
    output logic [W-1:0]  rd_data,
    output logic          rd_data_valid,
    output logic [W-1:0]  left_port,
    output logic          left_strobe,
    output logic [W-1:0]  right_port,
    output logic          right_strobe
);
    import iofm_pkg::*;

    localparam int NB = IOFM_NBANK;

    typedef struct packed {
        logic [NB-1:0][W-1:0] bank;
        logic [NB-1:0]        stb;
        logic [W-1:0]         rd_data;
        logic                 rd_vld;
    } iofm_state_t;

    iofm_state_t st_d, st_q;

    logic [W-1:0]         wval;
    logic [NB-1:0][W-1:0] merged;
    logic [NB-1:0][W-1:0] wmask;
    logic [NB-1:0]        wsel;
    logic [W-1:0]         rd_src;
    logic [W-1:0]         rd_field;

    // transmit flavour keeps only the immediate bits
    always_comb begin
        if (wr_xmit) begin
            wval = W'(wr_data[XMIT_W-1:0]);
        end else begin
            wval = wr_data;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign wsel[b] = wr_valid && (wr_bank == 1'(b));

        iofm_merge #(.W(W), .PW(PW)) u_merge (
            .cur      (st_q.bank[b]),
            .val      (wval),
            .pos      (wr_pos),
            .len_code (wr_len),
            .nxt      (merged[b]),
            .wmask    (wmask[b])
        );

        AST_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            wsel[b] |=> (((st_q.bank[b] ^ $past(st_q.bank[b])) & ~$past(wmask[b])) == '0)); // R4

        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wsel[b] |=> $stable(st_q.bank[b])); // R5

        AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            wsel[b] |=> st_q.stb[b]); // R6
    end

    // a same-cycle write to the read bank is seen by the read
    always_comb begin
        if (wsel[rd_bank]) begin
            rd_src = merged[rd_bank];
        end else begin
            rd_src = st_q.bank[rd_bank];
        end
    end

    iofm_extract #(.W(W), .PW(PW)) u_extract (
        .bank     (rd_src),
        .pos      (rd_pos),
        .len_code (rd_len),
        .field    (rd_field)
    );

    always_comb begin
        st_d        = st_q;
        st_d.stb    = '0;
        st_d.rd_vld = rd_valid;
        for (int b = 0; b < NB; b++) begin
            if (wsel[b]) begin
                st_d.bank[b] = merged[b];
                st_d.stb[b]  = 1'b1;
            end
        end
        if (rd_valid) begin
            st_d.rd_data = rd_field;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data       = st_q.rd_data;
    assign rd_data_valid = st_q.rd_vld;
    assign left_port     = st_q.bank[IOFM_LEFT];
    assign right_port    = st_q.bank[IOFM_RIGHT];
    assign left_strobe   = st_q.stb[IOFM_LEFT];
    assign right_strobe  = st_q.stb[IOFM_RIGHT];

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({left_strobe, right_strobe})); // R6

    AST_RD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_len != '0) |=> ((rd_data >> $past(rd_len)) == '0)); // R3

    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_data_valid); // R3

endmodule

// File: tb/iofield_unit_bench.sv
`timescale 1ns/1ps
module iofield_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, wr_bank = 1'b0, wr_xmit = 1'b0;
    logic [2:0] wr_pos = '0, wr_len = '0;
    logic [7:0] wr_data = '0;
    logic       rd_valid = 1'b0, rd_bank = 1'b0;
    logic [2:0] rd_pos = '0, rd_len = '0;
    logic [7:0] rd_data, left_port, right_port;
    logic       rd_data_valid, left_strobe, right_strobe;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [2];

    always #10 clk = ~clk;

    iofield_unit u_iofield_unit (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_xmit(wr_xmit),
        .wr_pos(wr_pos), .wr_len(wr_len), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_pos(rd_pos), .rd_len(rd_len),
        .rd_data(rd_data), .rd_data_valid(rd_data_valid),
        .left_port(left_port), .left_strobe(left_strobe),
        .right_port(right_port), .right_strobe(right_strobe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int flen(input logic [2:0] code);
        return (code == 3'd0) ? 8 : int'(code);
    endfunction

    // MSB-first position i is inside the field when pos-L < i <= pos
    function automatic logic [7:0] m_write(input logic [7:0] cur, input logic [7:0] val,
                                           input int pos, input int len);
        logic [7:0] r = cur;
        for (int i = 0; i < 8; i++) begin
            if (i <= pos && i + len > pos) r[7-i] = val[pos-i];
        end
        return r;
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] b, input int pos, input int len);
        logic [7:0] r = '0;
        for (int k = 0; k < len; k++) r[k] = b[(7 - pos + k) % 8];
        return r;
    endfunction

    task automatic check_ports(input string req, input logic sl, input logic sr);
        check({req, " left_port"}, left_port, mdl[0]);
        check({req, " right_port"}, right_port, mdl[1]);
        check({req, " left_strobe"}, {7'd0, left_strobe}, {7'd0, sl});
        check({req, " right_strobe"}, {7'd0, right_strobe}, {7'd0, sr});
    endtask

    // write, optionally with a simultaneous read; checks after the edge
    task automatic op(input logic wv, input logic wb, input logic wx, input logic [2:0] wp,
                      input logic [2:0] wl, input logic [7:0] wd,
                      input logic rv, input logic rb, input logic [2:0] rp,
                      input logic [2:0] rl, input string req);
        logic [7:0] val;
        logic [7:0] exp_rd;
        @(negedge clk);
        wr_valid = wv; wr_bank = wb; wr_xmit = wx; wr_pos = wp; wr_len = wl; wr_data = wd;
        rd_valid = rv; rd_bank = rb; rd_pos = rp; rd_len = rl;
        val = wx ? {3'b000, wd[4:0]} : wd;
        if (wv) mdl[wb] = m_write(mdl[wb], val, int'(wp), flen(wl));
        exp_rd = m_read(mdl[rb], int'(rp), flen(rl));
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        check_ports(req, wv && !wb, wv && wb);
        if (rv) begin
            check({req, " rd_data"}, rd_data, exp_rd);
            check({req, " rd_data_valid"}, {7'd0, rd_data_valid}, 8'd1);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mdl[0] = '0; mdl[1] = '0;
        repeat (3) @(negedge clk);
        check_ports("R1 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_ports("R1 after reset", 1'b0, 1'b0);
        check("R1 rd_data_valid", {7'd0, rd_data_valid}, 8'd0);

        // R2 R4 R5 R6 R7: every bank, position and length, plain and transmit
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 8; p++) begin
                for (int l = 0; l < 8; l++) begin
                    op(1'b1, 1'(b), 1'b0, 3'(p), 3'(l), 8'(8'h5A ^ (p * 37 + l * 11 + b)),
                       1'b0, 1'b0, 3'd0, 3'd0, "R4 plain write");
                    op(1'b1, 1'(b), 1'b1, 3'(p), 3'(l), 8'(8'hE7 ^ (p * 13 + l * 29)),
                       1'b0, 1'b0, 3'd0, 3'd0, "R7 transmit write");
                end
            end
        end

        // idle cycle: no strobe, no change (R5)
        @(negedge clk);
        check_ports("R5 idle", 1'b0, 1'b0);

        // R2 R3 R9: sweep reads of preloaded bytes
        op(1'b1, 1'b0, 1'b0, 3'd7, 3'd0, 8'hC6, 1'b0, 1'b0, 3'd0, 3'd0, "R2 full load left");
        op(1'b1, 1'b1, 1'b0, 3'd7, 3'd0, 8'h39, 1'b0, 1'b0, 3'd0, 3'd0, "R2 full load right");
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 8; p++) begin
                for (int l = 0; l < 8; l++) begin
                    op(1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00,
                       1'b1, 1'(b), 3'(p), 3'(l), "R3 R9 read");
                end
            end
        end

        // R8: same-bank bypass and other-bank read
        op(1'b1, 1'b1, 1'b0, 3'd5, 3'd3, 8'h05, 1'b1, 1'b1, 3'd7, 3'd0, "R8 same bank");
        op(1'b1, 1'b0, 1'b0, 3'd3, 3'd2, 8'h02, 1'b1, 1'b0, 3'd3, 3'd2, "R8 same field");
        op(1'b1, 1'b0, 1'b1, 3'd7, 3'd0, 8'hFF, 1'b1, 1'b1, 3'd4, 3'd5, "R8 other bank");
        op(1'b1, 1'b1, 1'b1, 3'd2, 3'd0, 8'hFF, 1'b1, 1'b0, 3'd6, 3'd0, "R8 R7 other bank");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule